// File: doc/BRIEF.md
# Decision-Directed Carrier Phase Tracker

This block tracks the residual carrier phase of a BPSK signal at baseband. For every symbol it receives the in-phase and quadrature matched-filter samples and a signed soft estimate of the transmitted bit. Multiplying both samples by that estimate strips the data modulation, so the loop sees a plain tone. The phase error against the sine and cosine of a numerically controlled oscillator drives a proportional-integral loop filter, and the filter drives the oscillator's phase accumulator.

For every symbol the block reports the phase estimate used for that symbol and a soft metric. The metric is the projection of the sample onto the estimated carrier, scaled by a programmable gain, and goes to a downstream iterative decoder. A start pulse opens a pass over one codeword of `BLOCK_LEN` symbols (1944 by default). A one-cycle done pulse closes the pass.

Before any decoder output exists, a seed mode derives the soft estimate from the sample component with the larger magnitude. This lets the first pass lock without feedback.

Top module: `ddcarrier_track`

## Requirements
- R1: After reset, `outValid` and `blockDone` are 0 and `phaseOut` and `metricOut` are 0.
- R2: A `start` pulse may arrive at any time. It loads `initPhase` into the oscillator and restarts the pass, so the first symbol after it reports `phaseOut == initPhase`.
- R3: `kp`, `ki`, `metricGain` and `useFeedback` are captured only on `start`. With both loop gains zero the phase estimate stays fixed for the whole pass, even if the gain inputs change after `start`.
- R4: The metric is floor((zc·cos + zs·sin)·metricGain / 2^19), where cos and sin are the oscillator outputs scaled by 2047 for the reported `phaseOut` and `metricGain` is unsigned with 8 fraction bits. The oscillator outputs are (cos, sin) = (2047, 0) at phase 0x0000 and (0, 2047) at phase 0x4000.
- R5: The metric saturates to the range -2048..2047.
- R6: In feedback mode, with the soft input equal to the transmitted sign times a constant, one pass with kp = 256 and ki = -256 brings the phase estimate to within 300 units (of a 65536-unit circle) of the carrier angle.
- R7: In feedback mode (`useFeedback` = 1) the soft estimate is `softIn`, so a zero soft input leaves the phase unchanged. In seed mode `softIn` is ignored and the estimate is the top 8 bits of whichever of zc and zs has the larger magnitude, with zc chosen on a tie. Seed mode locks within 400 units.
- R8: `blockDone` pulses for exactly one cycle, together with the `outValid` of symbol number `BLOCK_LEN`. Further symbols are ignored until the next `start`.
- R9: `symValid` has no effect before the first `start`.
- R10: The phase estimate wraps modulo 2^16, so the loop locks across the 0xFFFF to 0x0000 boundary.
- R11: The error e = floor((zs·y·cos − zc·y·sin) / 2^18), saturated to 13 bits. The filter state follows v_k = v_{k−1} + kp·e_k + ki·e_{k−1}, and the next phase is phase + floor(v_k / 2^8). The proportional term moves the phase reported for the next symbol; the integral term moves it one symbol later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a pass; loads phase, gains and mode |
| initPhase | input | 16 | Initial oscillator phase, full circle = 2^16 |
| kp | input | 16 | Signed proportional gain, 8 fraction bits |
| ki | input | 16 | Signed integral gain, 8 fraction bits |
| metricGain | input | 16 | Unsigned metric scale, 8 fraction bits |
| useFeedback | input | 1 | 1: soft input from decoder; 0: seed from stronger component |
| symValid | input | 1 | A symbol is present this cycle |
| zcIn | input | 12 | Signed in-phase sample |
| zsIn | input | 12 | Signed quadrature sample |
| softIn | input | 8 | Signed soft data estimate |
| outValid | output | 1 | Output for one symbol is present |
| phaseOut | output | 16 | Phase estimate used for that symbol |
| metricOut | output | 12 | Signed saturated soft metric |
| blockDone | output | 1 | Last symbol of the pass |

## Verification
A corrupted filter state or phase accumulator shows in `phaseOut` on the very next symbol. The bench therefore pins the proportional and integral paths to exact phase values two and three symbols into a pass. A wrong sine or cosine entry at the cardinal angles changes `metricOut` at once. A wrong sign or mode selection only appears as a failure to lock, so the bench checks it at the end of a full 1944-symbol pass. A miscounting controller moves or repeats `blockDone`, or lets symbols through after the pass, and the bench sees this within one block.

// File: rtl/ddct_pkg.sv
package ddct_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Control to datapath strobes
  typedef struct packed {
    logic load;  // capture configuration and initial phase
    logic step;  // process one symbol
  } ddctStrobe_t;

  // Elaboration-time quarter-wave sine value for entry idx of depth steps
  function automatic int quarterSine(input int idx, input int depth, input int amp);
    real x;
    real x2;
    real term;
    real acc;
    x    = 1.5707963267948966 * $itor(idx) / $itor(depth);
    x2   = x * x;
    term = x;
    acc  = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x2 / $itor((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return $rtoi(acc * $itor(amp) + 0.5);
  endfunction
endpackage

// File: rtl/ddct_trig.sv
module ddct_trig #(
  parameter int TRIG_W    = 12,
  parameter int LUT_ABITS = 6
) (
  input  logic [LUT_ABITS+1:0]      phaseTop,
  output logic signed [TRIG_W-1:0]  sinOut,
  output logic signed [TRIG_W-1:0]  cosOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int QDEPTH = 1 << LUT_ABITS;
  localparam int AMP    = (1 << (TRIG_W - 1)) - 1;

  // Quarter wave, QDEPTH+1 points so that the quarter angle is exact
  logic [TRIG_W-1:0] quarterTab [QDEPTH+1];

  for (genvar g = 0; g <= QDEPTH; g++) begin : gTab
    localparam int VAL = ddct_pkg::quarterSine(g, QDEPTH, AMP);
    assign quarterTab[g] = TRIG_W'(VAL);
  end

  logic [1:0]           quad;
  logic [LUT_ABITS:0]   idxFwd;
  logic [LUT_ABITS:0]   idxRev;
  logic signed [TRIG_W-1:0] valFwd;
  logic signed [TRIG_W-1:0] valRev;

  always_comb begin
    quad   = phaseTop[LUT_ABITS+1:LUT_ABITS];
    idxFwd = {1'b0, phaseTop[LUT_ABITS-1:0]};
    idxRev = (LUT_ABITS+1)'(QDEPTH) - idxFwd;
    valFwd = quarterTab[idxFwd];
    valRev = quarterTab[idxRev];
    unique case (quad)
      2'd0: begin sinOut = valFwd;  cosOut = valRev;  end
      2'd1: begin sinOut = valRev;  cosOut = -valFwd; end
      2'd2: begin sinOut = -valFwd; cosOut = -valRev; end
      default: begin sinOut = -valRev; cosOut = valFwd; end
    endcase
  end
endmodule

// File: rtl/ddct_ctrl.sv
module ddct_ctrl import ddct_pkg::*; #(
  parameter int BLOCK_LEN = 1944
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        symValid,
  output ddctStrobe_t strobe,
  output logic        outValid,
  output logic        blockDone
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(BLOCK_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);

  logic             running;
  logic [CNT_W-1:0] symCount;

  always_comb begin
    strobe.load = start;
    strobe.step = running && symValid && !start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      symCount  <= '0;
      outValid  <= 1'b0;
      blockDone <= 1'b0;
    end else begin
      outValid  <= strobe.step;
      blockDone <= strobe.step && (symCount == LAST);
      if (start) begin
        running  <= 1'b1;
        symCount <= '0;
      end else if (strobe.step) begin
        if (symCount == LAST) begin
          running  <= 1'b0;
          symCount <= '0;
        end else begin
          symCount <= symCount + 1'b1;
        end
      end
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (symCount <= LAST));

  assert_done_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> (outValid && !running));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> !outValid);
endmodule

// File: rtl/ddct_datapath.sv
module ddct_datapath import ddct_pkg::*; #(
  parameter int DATA_W    = 12,
  parameter int SOFT_W    = 8,
  parameter int TRIG_W    = 12,
  parameter int PH_W      = 16,
  parameter int LUT_ABITS = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ddctStrobe_t               strobe,
  input  logic [PH_W-1:0]           initPhase,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  input  logic [GAIN_W-1:0]         metricGain,
  input  logic                      useFeedback,
  input  logic signed [DATA_W-1:0]  zcIn,
  input  logic signed [DATA_W-1:0]  zsIn,
  input  logic signed [SOFT_W-1:0]  softIn,
  output logic [PH_W-1:0]           phaseOut,
  output logic signed [DATA_W-1:0]  metricOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AMP   = (1 << (TRIG_W - 1)) - 1;
  localparam int UW    = DATA_W + SOFT_W;
  localparam int EW_W  = UW + TRIG_W + 1;
  localparam int E_W   = DATA_W + 1;
  localparam int E_SH  = (TRIG_W - 1) + (SOFT_W - 1);
  localparam int V_W   = PH_W + GAIN_FRAC + 2;
  localparam int PW    = GAIN_W + E_W;
  localparam int SUM_W = ((PW > V_W) ? PW : V_W) + 2;
  localparam int PJ_W  = DATA_W + TRIG_W + 1;
  localparam int MG_W  = PJ_W + GAIN_W + 1;
  localparam int M_SH  = (TRIG_W - 1) + GAIN_FRAC;

  localparam logic signed [EW_W-1:0]  E_HI = {{(EW_W-E_W+1){1'b0}}, {(E_W-1){1'b1}}};
  localparam logic signed [EW_W-1:0]  E_LO = ~E_HI;
  localparam logic signed [SUM_W-1:0] V_HI = {{(SUM_W-V_W+1){1'b0}}, {(V_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] V_LO = ~V_HI;
  localparam logic signed [MG_W-1:0]  M_HI = {{(MG_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [MG_W-1:0]  M_LO = ~M_HI;

  // Captured configuration and loop state
  logic [PH_W-1:0]          phaseAcc;
  logic signed [GAIN_W-1:0] kpReg;
  logic signed [GAIN_W-1:0] kiReg;
  logic [GAIN_W-1:0]        gainReg;
  logic                     useFbReg;
  logic signed [E_W-1:0]    ePrev;
  logic signed [V_W-1:0]    vAcc;

  // Oscillator outputs for the current phase
  logic signed [TRIG_W-1:0] sinV;
  logic signed [TRIG_W-1:0] cosV;

  ddct_trig #(
    .TRIG_W   (TRIG_W),
    .LUT_ABITS(LUT_ABITS)
  ) u_trig (
    .phaseTop(phaseAcc[PH_W-1 -: LUT_ABITS+2]),
    .sinOut  (sinV),
    .cosOut  (cosV)
  );

  logic signed [DATA_W:0]   absZc;
  logic signed [DATA_W:0]   absZs;
  logic signed [SOFT_W-1:0] ySel;
  logic signed [UW-1:0]     usProd;
  logic signed [UW-1:0]     ucProd;
  logic signed [EW_W-1:0]   eWide;
  logic signed [EW_W-1:0]   eShift;
  logic signed [E_W-1:0]    eVal;
  logic signed [SUM_W-1:0]  vSum;
  logic signed [V_W-1:0]    vNext;
  logic [PH_W-1:0]          phaseStep;
  logic signed [PJ_W-1:0]   proj;
  logic signed [MG_W-1:0]   mWide;
  logic signed [MG_W-1:0]   mShift;
  logic signed [DATA_W-1:0] mVal;

  // Modulation wipe-off and phase detector
  always_comb begin
    absZc = (zcIn < 0) ? -(DATA_W+1)'(zcIn) : (DATA_W+1)'(zcIn);
    absZs = (zsIn < 0) ? -(DATA_W+1)'(zsIn) : (DATA_W+1)'(zsIn);
    if (useFbReg)
      ySel = softIn;
    else if (absZc >= absZs)
      ySel = zcIn[DATA_W-1 -: SOFT_W];
    else
      ySel = zsIn[DATA_W-1 -: SOFT_W];

    usProd = UW'(zsIn) * UW'(ySel);
    ucProd = UW'(zcIn) * UW'(ySel);
    eWide  = EW_W'(usProd) * EW_W'(cosV) - EW_W'(ucProd) * EW_W'(sinV);
    eShift = eWide >>> E_SH;
    if (eShift > E_HI)      eVal = E_HI[E_W-1:0];
    else if (eShift < E_LO) eVal = E_LO[E_W-1:0];
    else                    eVal = eShift[E_W-1:0];
  end

  // Proportional-integral filter with a saturating state
  always_comb begin
    vSum = SUM_W'(vAcc) + SUM_W'(kpReg) * SUM_W'(eVal) + SUM_W'(kiReg) * SUM_W'(ePrev);
    if (vSum > V_HI)      vNext = V_HI[V_W-1:0];
    else if (vSum < V_LO) vNext = V_LO[V_W-1:0];
    else                  vNext = vSum[V_W-1:0];
    phaseStep = vNext[GAIN_FRAC +: PH_W];
  end

  // Soft metric: projection onto the estimated carrier, scaled and saturated
  always_comb begin
    proj   = PJ_W'(zcIn) * PJ_W'(cosV) + PJ_W'(zsIn) * PJ_W'(sinV);
    mWide  = MG_W'(proj) * $signed({{(MG_W-GAIN_W){1'b0}}, gainReg});
    mShift = mWide >>> M_SH;
    if (mShift > M_HI)      mVal = M_HI[DATA_W-1:0];
    else if (mShift < M_LO) mVal = M_LO[DATA_W-1:0];
    else                    mVal = mShift[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      kpReg     <= '0;
      kiReg     <= '0;
      gainReg   <= '0;
      useFbReg  <= 1'b0;
      ePrev     <= '0;
      vAcc      <= '0;
      phaseOut  <= '0;
      metricOut <= '0;
    end else if (strobe.load) begin
      phaseAcc <= initPhase;
      kpReg    <= kp;
      kiReg    <= ki;
      gainReg  <= metricGain;
      useFbReg <= useFeedback;
      ePrev    <= '0;
      vAcc     <= '0;
    end else if (strobe.step) begin
      phaseAcc  <= phaseAcc + phaseStep;
      vAcc      <= vNext;
      ePrev     <= eVal;
      phaseOut  <= phaseAcc;
      metricOut <= mVal;
    end
  end

  // Checks
  int trigMag;
  always_comb begin
    trigMag = ((sinV < 0) ? -int'(sinV) : int'(sinV)) + ((cosV < 0) ? -int'(cosV) : int'(cosV));
  end

  assert_trig_unit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trigMag >= AMP - 1) && (trigMag <= AMP + AMP / 2));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(phaseAcc));

  assert_zero_gain_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (kpReg == 0 && kiReg == 0 && vAcc == 0 && !strobe.load) |=> $stable(phaseAcc));
endmodule

// File: rtl/ddcarrier_track.sv
module ddcarrier_track #(
  parameter int DATA_W    = 12,
  parameter int SOFT_W    = 8,
  parameter int TRIG_W    = 12,
  parameter int PH_W      = 16,
  parameter int LUT_ABITS = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int BLOCK_LEN = 1944
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [PH_W-1:0]          initPhase,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic [GAIN_W-1:0]        metricGain,
  input  logic                     useFeedback,
  input  logic                     symValid,
  input  logic signed [DATA_W-1:0] zcIn,
  input  logic signed [DATA_W-1:0] zsIn,
  input  logic signed [SOFT_W-1:0] softIn,
  output logic                     outValid,
  output logic [PH_W-1:0]          phaseOut,
  output logic signed [DATA_W-1:0] metricOut,
  output logic                     blockDone
);
  timeunit 1ns;
  timeprecision 1ps;

  ddct_pkg::ddctStrobe_t strobe;

  ddct_ctrl #(
    .BLOCK_LEN(BLOCK_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .symValid (symValid),
    .strobe   (strobe),
    .outValid (outValid),
    .blockDone(blockDone)
  );

  ddct_datapath #(
    .DATA_W   (DATA_W),
    .SOFT_W   (SOFT_W),
    .TRIG_W   (TRIG_W),
    .PH_W     (PH_W),
    .LUT_ABITS(LUT_ABITS),
    .GAIN_W   (GAIN_W),
    .GAIN_FRAC(GAIN_FRAC)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .initPhase  (initPhase),
    .kp         (kp),
    .ki         (ki),
    .metricGain (metricGain),
    .useFeedback(useFeedback),
    .zcIn       (zcIn),
    .zsIn       (zsIn),
    .softIn     (softIn),
    .phaseOut   (phaseOut),
    .metricOut  (metricOut)
  );
endmodule

// File: tb/ddcarrier_track_bench.sv
module ddcarrier_track_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BLK = 1944;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [15:0]        initPhase = '0;
  logic signed [15:0] kp = '0;
  logic signed [15:0] ki = '0;
  logic [15:0]        metricGain = '0;
  logic               useFeedback = 1'b1;
  logic               symValid = 1'b0;
  logic signed [11:0] zcIn = '0;
  logic signed [11:0] zsIn = '0;
  logic signed [7:0]  softIn = '0;
  logic               outValid;
  logic [15:0]        phaseOut;
  logic signed [11:0] metricOut;
  logic               blockDone;

  int total = 0;
  int bad = 0;
  bit runOver = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  ddcarrier_track u_ddcarrier_track (
    .clk(clk), .rstN(rstN), .start(start), .initPhase(initPhase),
    .kp(kp), .ki(ki), .metricGain(metricGain), .useFeedback(useFeedback),
    .symValid(symValid), .zcIn(zcIn), .zsIn(zsIn), .softIn(softIn),
    .outValid(outValid), .phaseOut(phaseOut), .metricOut(metricOut),
    .blockDone(blockDone)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkNear(input string req, input logic [15:0] act, input int target, input int tol);
    logic signed [15:0] diff;
    diff = act - 16'(target);
    total++;
    if (int'(diff) > tol || int'(diff) < -tol) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d+-%0d", req, act, target, tol);
    end
  endtask

  task automatic doStart(input int ph, input int kpv, input int kiv, input int gain, input bit fb);
    @(negedge clk);
    symValid    = 1'b0;
    start       = 1'b1;
    initPhase   = 16'(ph);
    kp          = 16'(kpv);
    ki          = 16'(kiv);
    metricGain  = 16'(gain);
    useFeedback = fb;
    @(posedge clk);
    #1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendSym(input int zc, input int zs, input int sf);
    @(negedge clk);
    symValid = 1'b1;
    zcIn     = 12'(zc);
    zsIn     = 12'(zs);
    softIn   = 8'(sf);
    @(posedge clk);
    #1;
  endtask

  task automatic relax();
    @(negedge clk);
    symValid = 1'b0;
  endtask

  // Runs count symbols of a BPSK stream with fixed carrier components
  task automatic runStream(input int count, input int firstIdx, input int zcA, input int zsA,
                           input int sfMag, output logic [15:0] lastPhase, output int doneErr);
    doneErr = 0;
    for (int i = 0; i < count; i++) begin
      bit d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = lfsr[0];
      sendSym(d ? zcA : -zcA, d ? zsA : -zsA, d ? sfMag : -sfMag);
      if (outValid !== 1'b1) doneErr++;
      if (blockDone !== ((firstIdx + i) == BLK - 1)) doneErr++;
      lastPhase = phaseOut;
    end
    relax();
  endtask

  task automatic testReset();
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 blockDone after reset", int'(blockDone), 0);
    chk("R1 phaseOut after reset", int'(phaseOut), 0);
    chk("R1 metricOut after reset", int'(metricOut), 0);
    sendSym(300, 0, 50);
    chk("R9 no output before start", int'(outValid), 0);
    relax();
    @(posedge clk); #1;
    chk("R9 still idle", int'(outValid), 0);
  endtask

  task automatic testHoldAndMetric();
    logic [15:0] lp;
    int derr;
    doStart(0, 0, 0, 512, 1'b1);
    sendSym(300, 0, 100);
    chk("R2 first phase equals init", int'(phaseOut), 0);
    chk("R4 metric at phase 0, +300", int'(metricOut), 599);
    sendSym(-300, 0, 100);
    chk("R4 metric at phase 0, -300", int'(metricOut), -600);
    sendSym(2000, 0, 100);
    chk("R5 positive saturation", int'(metricOut), 2047);
    sendSym(-2000, 0, 100);
    chk("R5 negative saturation", int'(metricOut), -2048);
    kp = 16'sd1000;
    ki = 16'sd500;
    metricGain = 16'd64;
    for (int i = 0; i < 10; i++) sendSym(0, 1000, 100);
    chk("R3 phase held with zero captured gains", int'(phaseOut), 0);
    sendSym(-300, 0, 100);
    chk("R3 metric gain captured at start", int'(metricOut), -600);
    runStream(BLK - 15, 15, 0, 1000, 100, lp, derr);
    chk("R3 phase held to block end", int'(lp), 0);
    chk("R8 done only on last symbol", derr, 0);
    sendSym(500, 0, 100);
    chk("R8 symbol after block ignored", int'(outValid), 0);
    chk("R8 no repeated done", int'(blockDone), 0);
    relax();
  endtask

  task automatic testQuarter();
    doStart(16'h4000, 0, 0, 256, 1'b1);
    sendSym(0, 1000, 10);
    chk("R2 init phase 0x4000", int'(phaseOut), 16'h4000);
    chk("R4 metric at phase 0x4000, zs=1000", int'(metricOut), 999);
    sendSym(500, -1000, 10);
    chk("R4 metric at phase 0x4000, zs=-1000", int'(metricOut), -1000);
    relax();
  endtask

  task automatic testFilterPaths();
    doStart(0, 256, 0, 256, 1'b1);
    sendSym(0, 1000, 100);
    chk("R11 kp path symbol 1", int'(phaseOut), 0);
    sendSym(0, 1000, 100);
    chk("R11 kp path symbol 2", int'(phaseOut), 780);
    relax();
    doStart(0, 0, 256, 256, 1'b1);
    sendSym(0, 1000, 100);
    chk("R11 ki path symbol 1", int'(phaseOut), 0);
    sendSym(0, 1000, 100);
    chk("R11 ki path symbol 2", int'(phaseOut), 0);
    sendSym(0, 1000, 100);
    chk("R11 ki path symbol 3", int'(phaseOut), 780);
    relax();
  endtask

  task automatic testLock();
    logic [15:0] lp;
    int derr;
    doStart(0, 256, -256, 256, 1'b1);
    runStream(BLK, 0, 0, 1000, 100, lp, derr);
    chkNear("R6 lock at 90 degrees", lp, 16'h4000, 300);
    chk("R8 done on block of lock run", derr, 0);
    doStart(16'hF000, 256, -256, 256, 1'b1);
    runStream(BLK, 0, 1000, 0, 100, lp, derr);
    chkNear("R10 lock across wrap to 0", lp, 0, 300);
  endtask

  task automatic testSeed();
    logic [15:0] lp;
    int derr;
    doStart(0, 256, -256, 256, 1'b0);
    runStream(BLK, 0, 866, 500, 0, lp, derr);
    chkNear("R7 seed mode lock at 30 degrees", lp, 5461, 400);
    chk("R8 done in seed run", derr, 0);
    doStart(16'h2000, 256, -256, 256, 1'b1);
    runStream(BLK, 0, 866, 500, 0, lp, derr);
    chk("R7 zero soft input leaves phase", int'(lp), 16'h2000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHoldAndMetric();
    testQuarter();
    testFilterPaths();
    testLock();
    testSeed();
    runOver = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!runOver) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule